// File: doc/BRIEF.md
# Operand Address Former

This block turns the addressing information of one memory operand into the address that the load/store path uses. Each request carries an addressing-mode code, the value read from the named register, an optional second register value, a displacement field, the program counter and the operand size. The block adds the correct terms with 32-bit wrap-around and registers the result. When a mode changes the register, it also returns the new register value and a write-back strobe.

Two modes never touch memory: an immediate operand and a register operand. For these the block raises a flag in place of an address. The pointer-through-memory mode takes more than one cycle. The block first sends out a read of the pointer location and holds it until the memory acknowledges. The returned word then becomes the final address. While this read is outstanding the block reports busy and drops any new request. Decoding the instruction, driving the memory and holding the register file belong to the surrounding pipeline.

Top module: `eag_unit`

## Requirements
- R1: After reset `ea_valid`, `wb_en`, `ptr_rd` and `busy` are all low.
- R2: Mode codes are 0 immediate, 1 register, 2 register-indirect, 3 displaced, 4 two-register, 5 two-register plus displacement, 6 counter-relative, 7 post-increment, 8 pre-decrement and 9 pointer-through-memory. Codes 10 to 15 behave like code 1. Modes 0, 1 and 10 to 15 give `ea_valid` with `no_mem`=1 and `wb_en`=0.
- R3: Register-indirect gives `ea` = `reg_val`.
- R4: The displaced mode gives `ea` = extended displacement + `reg_val`. It appears with `ea_valid` on the clock edge after the edge that accepted the request, and the same latency holds for every mode except 9.
- R5: With `disp_wide`=0 only `disp[7:0]` is used, sign-extended from bit 7. With `disp_wide`=1 all 16 bits are used, sign-extended from bit 15.
- R6: Mode 4 gives `reg_val` + `idx_val`. Mode 5 gives extended displacement + `reg_val` + `idx_val`.
- R7: Mode 6 gives `pc` + extended displacement, so a negative displacement reaches below the counter.
- R8: Mode 7 gives `ea` = `reg_val`, `wb_val` = `reg_val` + step, `wb_idx` = `reg_idx` and `wb_en`=1. `wb_en` is high in no other mode.
- R9: Mode 8 gives `ea` = `wb_val` = `reg_val` − step, with `wb_en`=1.
- R10: The step is 1, 2, 4 or 4 for `op_size` 0, 1, 2 or 3.
- R11: Mode 9 raises `ptr_rd` with `ptr_addr` = extended displacement + `reg_val` and holds both until `ptr_ack`. On the next edge `ea_valid`=1, `ea` = the `ptr_data` sampled with the acknowledge, `ptr_rd`=0, `no_mem`=0 and `wb_en`=0.
- R12: While `busy` is high, `req_valid` is ignored: no `ea_valid` appears and `ptr_addr` does not move.
- R13: All sums and differences wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| reg_idx | input | 4 | Index of the named register |
| reg_val | input | 32 | Value of the named register |
| idx_val | input | 32 | Value of the second register |
| disp | input | 16 | Displacement field |
| disp_wide | input | 1 | 1: use the 16-bit displacement, 0: use the 8-bit one |
| pc | input | 32 | Program counter |
| op_size | input | 2 | Operand size code |
| ptr_ack | input | 1 | Pointer read completed |
| ptr_data | input | 32 | Pointer read data |
| ea_valid | output | 1 | Result valid, one-cycle pulse |
| ea | output | 32 | Effective address |
| no_mem | output | 1 | Operand needs no memory access |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 4 | Write-back register index |
| wb_val | output | 32 | Write-back value |
| ptr_rd | output | 1 | Pointer read request |
| ptr_addr | output | 32 | Pointer read address |
| busy | output | 1 | Pointer read outstanding |

## Verification
The checker relies on two things about the memory side. It assumes `ptr_ack` arrives only while `ptr_rd` is high. It also assumes `ptr_data` is valid in the same cycle as that acknowledge. The stimulus raises the acknowledge only after it has seen the pointer request, and only for one cycle. It then holds the request inputs steady except in the test that issues a request on purpose while the block is busy. Operand sizes and reserved mode codes are swept in full, because the block gives them defined behaviour.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam logic [3:0] M_IMM   = 4'd0;
    localparam logic [3:0] M_REG   = 4'd1;
    localparam logic [3:0] M_RIND  = 4'd2;
    localparam logic [3:0] M_DISP  = 4'd3;
    localparam logic [3:0] M_BIDX  = 4'd4;
    localparam logic [3:0] M_BIDXO = 4'd5;
    localparam logic [3:0] M_PCREL = 4'd6;
    localparam logic [3:0] M_AINC  = 4'd7;
    localparam logic [3:0] M_ADEC  = 4'd8;
    localparam logic [3:0] M_MIND  = 4'd9;

    typedef enum logic {S_IDLE, S_WAIT} eag_state_e;

    typedef struct packed {
        logic no_mem;
        logic wb_en;
        logic need_ptr;
    } eag_ctl_t;

    function automatic logic [2:0] step_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic eag_ctl_t decode_mode(input logic [3:0] m);
        eag_ctl_t c;
        c = '{no_mem: 1'b0, wb_en: 1'b0, need_ptr: 1'b0};
        case (m)
            M_RIND, M_DISP, M_BIDX, M_BIDXO, M_PCREL: ;
            M_AINC, M_ADEC: c.wb_en    = 1'b1;
            M_MIND:         c.need_ptr = 1'b1;
            default:        c.no_mem   = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext #(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic [DISP_W-1:0] disp,
    input  logic              wide,
    output logic [ADDR_W-1:0] ext
);
    logic signed [DISP_W-1:0]  d_long;
    logic signed [SHORT_W-1:0] d_short;

    always_comb begin
        d_long  = disp;
        d_short = disp[SHORT_W-1:0];
        ext = wide ? ADDR_W'(d_long) : ADDR_W'(d_short);
    end
endmodule

// File: rtl/eag_step.sv
module eag_step #(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        op_size,
    output logic [ADDR_W-1:0] step
);
    always_comb step = ADDR_W'(eag_pkg::step_bytes(op_size));
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
    parameter int ADDR_W = 32
) (
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] disp_x,
    input  logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] wb_val
);
    import eag_pkg::*;

    logic [ADDR_W-1:0] disp_plus_reg;

    always_comb begin
        disp_plus_reg = disp_x + reg_val;
        addr   = '0;
        wb_val = reg_val;
        case (mode)
            M_RIND:  addr = reg_val;
            M_DISP:  addr = disp_plus_reg;
            M_BIDX:  addr = reg_val + idx_val;
            M_BIDXO: addr = disp_plus_reg + idx_val;
            M_PCREL: addr = pc + disp_x;
            M_AINC: begin
                addr   = reg_val;
                wb_val = reg_val + step;
            end
            M_ADEC: begin
                wb_val = reg_val - step;
                addr   = wb_val;
            end
            M_MIND:  addr = disp_plus_reg;
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit #(
    parameter int ADDR_W  = 32,
    parameter int DISP_W  = 16,
    parameter int SHORT_W = 8,
    parameter int RIDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        mode,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [DISP_W-1:0] disp,
    input  logic              disp_wide,
    input  logic [ADDR_W-1:0] pc,
    input  logic [1:0]        op_size,
    input  logic              ptr_ack,
    input  logic [ADDR_W-1:0] ptr_data,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              no_mem,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [ADDR_W-1:0] wb_val,
    output logic              ptr_rd,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              busy
);
    import eag_pkg::*;

    eag_state_e        state;
    eag_ctl_t          ctl;
    logic [ADDR_W-1:0] disp_x, step, calc_addr, calc_wb;

    eag_disp_ext #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W)) u_ext (
        .disp(disp), .wide(disp_wide), .ext(disp_x)
    );

    eag_step #(.ADDR_W(ADDR_W)) u_step (.op_size(op_size), .step(step));

    eag_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
        .mode(mode), .reg_val(reg_val), .idx_val(idx_val), .pc(pc),
        .disp_x(disp_x), .step(step), .addr(calc_addr), .wb_val(calc_wb)
    );

    always_comb ctl = decode_mode(mode);
    assign busy = (state == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            ea_valid <= 1'b0;
            ea       <= '0;
            no_mem   <= 1'b0;
            wb_en    <= 1'b0;
            wb_idx   <= '0;
            wb_val   <= '0;
            ptr_rd   <= 1'b0;
            ptr_addr <= '0;
        end else begin
            ea_valid <= 1'b0;
            wb_en    <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        if (ctl.need_ptr) begin
                            state    <= S_WAIT;
                            ptr_rd   <= 1'b1;
                            ptr_addr <= calc_addr;
                        end else begin
                            ea_valid <= 1'b1;
                            ea       <= ctl.no_mem ? '0 : calc_addr;
                            no_mem   <= ctl.no_mem;
                            wb_en    <= ctl.wb_en;
                            wb_idx   <= reg_idx;
                            wb_val   <= calc_wb;
                        end
                    end
                end
                S_WAIT: begin
                    if (ptr_ack) begin
                        state    <= S_IDLE;
                        ptr_rd   <= 1'b0;
                        ea_valid <= 1'b1;
                        ea       <= ptr_data;
                        no_mem   <= 1'b0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [3:0]        mode,
    input logic              ptr_ack,
    input logic [ADDR_W-1:0] ptr_data,
    input logic              ea_valid,
    input logic [ADDR_W-1:0] ea,
    input logic              no_mem,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_val,
    input logic              ptr_rd,
    input logic [ADDR_W-1:0] ptr_addr,
    input logic              busy
);
    logic [ADDR_W-1:0] gap;
    assign gap = wb_val - ea;

    p_wb_with_addr_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (ea_valid && !no_mem));

    p_wb_step_r10: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (gap == '0 || gap == ADDR_W'(1) || gap == ADDR_W'(2) || gap == ADDR_W'(4)));

    p_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && mode != 4'd9) |=> ea_valid);

    p_ptr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (ptr_rd && !ptr_ack) |=> (ptr_rd && $stable(ptr_addr)));

    p_ptr_done_r11: assert property (@(posedge clk) disable iff (rst)
        (ptr_rd && ptr_ack) |=> (ea_valid && !ptr_rd && !wb_en && ea == $past(ptr_data)));

    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && !ptr_ack) |=> !ea_valid);
endmodule

bind eag_unit eag_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
    .ptr_ack(ptr_ack), .ptr_data(ptr_data), .ea_valid(ea_valid), .ea(ea),
    .no_mem(no_mem), .wb_en(wb_en), .wb_val(wb_val), .ptr_rd(ptr_rd),
    .ptr_addr(ptr_addr), .busy(busy)
);

// File: tb/eag_unit_bench.sv
`timescale 1ns/1ps
module eag_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_val = '0, idx_val = '0, pc = '0, ptr_data = '0;
    logic [15:0] disp = '0;
    logic        disp_wide = 1'b0;
    logic [1:0]  op_size = '0;
    logic        ptr_ack = 1'b0;
    logic        ea_valid, no_mem, wb_en, ptr_rd, busy;
    logic [31:0] ea, wb_val, ptr_addr;
    logic [3:0]  wb_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    eag_unit u_eag_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .reg_idx(reg_idx),
        .reg_val(reg_val), .idx_val(idx_val), .disp(disp), .disp_wide(disp_wide),
        .pc(pc), .op_size(op_size), .ptr_ack(ptr_ack), .ptr_data(ptr_data),
        .ea_valid(ea_valid), .ea(ea), .no_mem(no_mem), .wb_en(wb_en),
        .wb_idx(wb_idx), .wb_val(wb_val), .ptr_rd(ptr_rd), .ptr_addr(ptr_addr),
        .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // displacement extension computed arithmetically (R5)
    function automatic logic [31:0] sx(input logic [15:0] d, input bit w);
        longint v;
        if (w) v = (d >= 16'h8000) ? longint'(d) - 65536 : longint'(d);
        else   v = (d[7:0] >= 8'h80) ? longint'(d[7:0]) - 256 : longint'(d[7:0]);
        return v[31:0];
    endfunction

    function automatic logic [31:0] stepv(input logic [1:0] s);
        return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic string tag_of(input int m);
        case (m)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R4";
            4, 5:    return "R6";
            6:       return "R7";
            7:       return "R8";
            8:       return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic issue(input logic [3:0] m, input logic [31:0] rv, input logic [31:0] iv,
                         input logic [15:0] d, input bit w, input logic [31:0] p,
                         input logic [1:0] s, input logic [3:0] ri);
        @(negedge clk);
        req_valid = 1'b1; mode = m; reg_val = rv; idx_val = iv; disp = d;
        disp_wide = w; pc = p; op_size = s; reg_idx = ri;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_result(input int m, input logic [31:0] rv, input logic [31:0] iv,
                                 input logic [15:0] d, input bit w, input logic [31:0] p,
                                 input logic [1:0] s, input logic [3:0] ri);
        logic [31:0] dx, e_ea, e_wb;
        bit e_nm, e_we, ok;
        dx = sx(d, w);
        e_nm = (m <= 1) || (m >= 10);
        e_we = (m == 7) || (m == 8);
        e_ea = '0; e_wb = '0;
        case (m)
            2: e_ea = rv;
            3: e_ea = dx + rv;
            4: e_ea = rv + iv;
            5: e_ea = dx + rv + iv;
            6: e_ea = p + dx;
            7: begin e_ea = rv; e_wb = rv + stepv(s); end
            8: begin e_wb = rv - stepv(s); e_ea = e_wb; end
            default: ;
        endcase
        ok = ea_valid && (no_mem == e_nm) && (wb_en == e_we) && !ptr_rd
             && (e_nm || ea == e_ea)
             && (!e_we || (wb_val == e_wb && wb_idx == ri));
        check(ok, tag_of(m), e_we ? wb_val : ea, e_we ? e_wb : e_ea);
    endtask

    task automatic run_one(input int m, input logic [31:0] rv, input logic [31:0] iv,
                           input logic [15:0] d, input bit w, input logic [31:0] p,
                           input logic [1:0] s, input logic [3:0] ri);
        issue(4'(m), rv, iv, d, w, p, s, ri);
        expect_result(m, rv, iv, d, w, p, s, ri);
    endtask

    task automatic pointer_case(input logic [31:0] rv, input logic [15:0] d, input bit w,
                                input logic [31:0] pdata, input int waits, input bit poke);
        logic [31:0] e_pa;
        e_pa = sx(d, w) + rv;
        issue(4'd9, rv, 32'h0, d, w, 32'h0, 2'd2, 4'd3);
        check(ptr_rd && busy && !ea_valid && ptr_addr == e_pa, "R11 request", ptr_addr, e_pa);
        if (poke) begin
            // R12: a request during the wait must be dropped
            @(negedge clk);
            req_valid = 1'b1; mode = 4'd3; reg_val = 32'h5555_0000; disp = 16'h0010;
            @(negedge clk);
            req_valid = 1'b0;
            check(!ea_valid && ptr_rd && ptr_addr == e_pa, "R12 ignored", ptr_addr, e_pa);
        end
        for (int k = 0; k < waits; k++) @(negedge clk);
        check(ptr_rd && !ea_valid && ptr_addr == e_pa, "R11 hold", ptr_addr, e_pa);
        ptr_ack = 1'b1; ptr_data = pdata;
        @(negedge clk);
        ptr_ack = 1'b0; ptr_data = 32'h0;
        check(ea_valid && ea == pdata && !no_mem && !wb_en && !ptr_rd && !busy,
              "R11 final", ea, pdata);
        @(negedge clk);
        check(!ea_valid, "R12 no late result", {31'h0, ea_valid}, 32'h0);
    endtask

    initial begin
        logic [31:0] regs  [4];
        logic [15:0] disps [6];
        regs  = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0001_0000, 32'h7FFF_FFF0};
        disps = '{16'h0000, 16'h007F, 16'h0080, 16'hFF80, 16'h8000, 16'h1234};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!ea_valid && !wb_en && !ptr_rd && !busy, "R1 reset",
              {28'h0, ea_valid, wb_en, ptr_rd, busy}, 32'h0);

        for (int m = 0; m <= 8; m++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++)
                    for (int ri = 0; ri < 4; ri++)
                        for (int di = 0; di < 6; di++)
                            run_one(m, regs[ri], regs[(ri + 1) % 4], disps[di], w[0],
                                    regs[(ri + 2) % 4], 2'(s), 4'((m + di) % 16));

        // R2: reserved codes act as register operands
        for (int m = 10; m < 16; m++)
            run_one(m, 32'h1234_5678, 32'h1, 16'h0004, 1'b1, 32'h100, 2'd0, 4'd2);

        // R5: the same field read narrow and wide
        run_one(3, 32'h0000_0100, 32'h0, 16'h0080, 1'b0, 32'h0, 2'd0, 4'd1);
        check(ea == 32'h0000_0080, "R5 narrow", ea, 32'h0000_0080);
        run_one(3, 32'h0000_0100, 32'h0, 16'h0080, 1'b1, 32'h0, 2'd0, 4'd1);
        check(ea == 32'h0000_0180, "R5 wide", ea, 32'h0000_0180);

        // R10: reserved size code steps by four
        run_one(7, 32'h0000_0020, 32'h0, 16'h0, 1'b0, 32'h0, 2'd3, 4'd5);
        check(wb_val == 32'h0000_0024, "R10 size3", wb_val, 32'h0000_0024);

        // R13: wrap-around
        run_one(3, 32'hFFFF_FFFF, 32'h0, 16'h0001, 1'b1, 32'h0, 2'd0, 4'd0);
        check(ea == 32'h0, "R13 add wrap", ea, 32'h0);
        run_one(8, 32'h0000_0000, 32'h0, 16'h0, 1'b0, 32'h0, 2'd2, 4'd6);
        check(ea == 32'hFFFF_FFFC && wb_val == 32'hFFFF_FFFC, "R13 sub wrap", ea, 32'hFFFF_FFFC);

        // R7: backward counter-relative
        run_one(6, 32'h0, 32'h0, 16'hFFF0, 1'b1, 32'h0000_2000, 2'd0, 4'd0);
        check(ea == 32'h0000_1FF0, "R7 backward", ea, 32'h0000_1FF0);

        pointer_case(32'h0000_4000, 16'hFFF0, 1'b1, 32'hCAFE_0000, 0, 1'b0);
        pointer_case(32'h0000_4000, 16'h00F0, 1'b0, 32'h1234_5678, 3, 1'b1);
        pointer_case(32'hFFFF_FFF0, 16'h0020, 1'b1, 32'h0000_0004, 1, 1'b1);

        // R4 after pointer mode: block accepts requests again
        run_one(3, 32'h0000_1000, 32'h0, 16'h0008, 1'b1, 32'h0, 2'd0, 4'd9);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule